// File: doc/BRIEF.md
# Card Identification Controller

This block holds the card-side control state for a removable memory card as it is powered up and identified on a shared command bus. A command decoder in front of it delivers one strobe for each received command. The strobe carries the command index, the 32-bit argument and four qualifiers:

- whether the checksum was good,
- whether the host's voltage window covers the card,
- whether the card is still busy powering up internally,
- whether the card lost bus arbitration while broadcasting its identity.

The block decides the next state, whether the card answers the command, and whether the command was out of place. It also keeps the 16-bit relative address that the host assigns to the card.

The states are idle, ready, identification, standby and inactive. A power-on reset puts the card into idle; no other reset pin is used. After that, only decoded commands move the state. A command with a bad checksum, or one outside the supported command set, is dropped silently. A supported command that does not fit the current state leaves the state as it is and raises a short warning pulse.

Top module: `card_ident_fsm`

## Requirements
- R1: After `por_n` is low and then released, `state_o` is 4'd0 (idle), `rca_o` is 0, and both `resp_en_o` and `illegal_o` are low. The state codes are 0 idle, 1 ready, 2 identification, 3 standby and 15 inactive.
- R2: In idle, index 1 (operating condition) with `volt_ok`=1 and `busy`=0 moves the state to ready and pulses `resp_en_o`.
- R3: In idle, index 1 with `volt_ok`=1 and `busy`=1 keeps the state in idle and pulses `resp_en_o`.
- R4: In idle, index 1 with `volt_ok`=0 moves the state to inactive (15) with no response. In inactive, every command is ignored, including index 0: no state change, no response and no illegal pulse. Only `por_n` leaves inactive.
- R5: In ready, index 2 (identity broadcast) with `arb_lost`=1 keeps the state in ready with no response. With `arb_lost`=0 it moves the state to identification and pulses `resp_en_o`.
- R6: In identification, index 3 (address assignment) loads `rca_o` from argument bits 31:16, moves the state to standby and pulses `resp_en_o`.
- R7: Index 0 (soft reset) in idle, ready, identification or standby moves the state to idle, clears `rca_o` and gives no response.
- R8: A strobe with `crc_ok`=0, or with an index whose bit is clear in `CMD_MASK`, has no effect. The default mask holds indices 0-3, 7, 9, 10, 12, 13, 15, 16, 17 and 18, so index 24 is unsupported. Such a strobe leaves the state and `rca_o` unchanged, with no response and no illegal pulse.
- R9: A good, supported command that has no transition in the current state leaves the state unchanged, gives no response and raises `illegal_o` for exactly one cycle.
- R10: All outputs are registered. The effect of a strobe seen at one rising edge is visible from that edge on. `resp_en_o` and `illegal_o` fall at the next edge unless another strobe raises them again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| crc_ok | input | 1 | Checksum of the command was good |
| volt_ok | input | 1 | Host voltage window covers the card |
| busy | input | 1 | Card still busy powering up internally |
| arb_lost | input | 1 | Card lost arbitration during the identity broadcast |
| state_o | output | 4 | Current state code |
| resp_en_o | output | 1 | Card answers the command (one-cycle pulse) |
| illegal_o | output | 1 | Command was out of place (one-cycle pulse) |
| rca_o | output | 16 | Assigned relative address |

## Verification
The state register drives `state_o` directly, so a wrong transition shows on the port one edge after the strobe that caused it. The bench checks the state code after every command. A lost arbitration or a busy card still visibly holds the state, and each of those cases comes with its own response expectation. A filter that is wrong would show as an illegal pulse or a response where none belongs, in the cycle after a bad-checksum or unsupported command. A missed address load or clear shows on `rca_o` in the same cycle as the standby or idle code.

// File: rtl/card_ident_fsm.sv
module card_ident_fsm #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int RCA_W = 16,
  parameter logic [(1<<IDX_W)-1:0] CMD_MASK = 64'h0000_0000_0007_B68F,
  parameter int IDX_SWRST = 0,
  parameter int IDX_OPCOND = 1,
  parameter int IDX_CIDBC = 2,
  parameter int IDX_SETRCA = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             crc_ok,
  input  logic             volt_ok,
  input  logic             busy,
  input  logic             arb_lost,
  output logic [3:0]       state_o,
  output logic             resp_en_o,
  output logic             illegal_o,
  output logic [RCA_W-1:0] rca_o
);

  localparam logic [3:0] ST_IDLE  = 4'd0;
  localparam logic [3:0] ST_READY = 4'd1;
  localparam logic [3:0] ST_IDENT = 4'd2;
  localparam logic [3:0] ST_STBY  = 4'd3;
  localparam logic [3:0] ST_INACT = 4'd15;

  logic [3:0] state_d;
  logic resp_d, ill_d, rca_ld, rca_clr;

  wire supported = CMD_MASK[cmd_index];
  wire accept    = cmd_valid && crc_ok && supported && (state_o != ST_INACT);
  wire is_rst    = cmd_index == IDX_W'(IDX_SWRST);
  wire is_op     = cmd_index == IDX_W'(IDX_OPCOND);
  wire is_cid    = cmd_index == IDX_W'(IDX_CIDBC);
  wire is_rca    = cmd_index == IDX_W'(IDX_SETRCA);

  always_comb begin
    state_d = state_o;
    resp_d  = 1'b0;
    ill_d   = 1'b0;
    rca_ld  = 1'b0;
    rca_clr = 1'b0;
    if (accept) begin
      if (is_rst) begin
        state_d = ST_IDLE;
        rca_clr = 1'b1;
      end else begin
        case (state_o)
          ST_IDLE:
            if (is_op) begin
              if (!volt_ok) state_d = ST_INACT;
              else begin
                resp_d = 1'b1;
                if (!busy) state_d = ST_READY;
              end
            end else ill_d = 1'b1;
          ST_READY:
            if (is_cid) begin
              if (!arb_lost) begin
                state_d = ST_IDENT;
                resp_d  = 1'b1;
              end
            end else ill_d = 1'b1;
          ST_IDENT:
            if (is_rca) begin
              state_d = ST_STBY;
              resp_d  = 1'b1;
              rca_ld  = 1'b1;
            end else ill_d = 1'b1;
          default: ill_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_o   <= ST_IDLE;
      resp_en_o <= 1'b0;
      illegal_o <= 1'b0;
      rca_o     <= '0;
    end else begin
      state_o   <= state_d;
      resp_en_o <= resp_d;
      illegal_o <= ill_d;
      if (rca_clr)     rca_o <= '0;
      else if (rca_ld) rca_o <= cmd_arg[ARG_W-1 -: RCA_W];
    end
  end

  assert_busy_stays_idle_R3: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid && crc_ok && is_op && state_o == ST_IDLE && volt_ok && busy
    |=> state_o == ST_IDLE && resp_en_o);

  assert_inactive_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    state_o == ST_INACT |=> state_o == ST_INACT && !resp_en_o && !illegal_o);

  assert_rca_capture_R6: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid && crc_ok && is_rca && state_o == ST_IDENT
    |=> rca_o == $past(cmd_arg[ARG_W-1 -: RCA_W]) && state_o == ST_STBY);

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid && crc_ok && is_rst && state_o != ST_INACT
    |=> state_o == ST_IDLE && rca_o == '0 && !resp_en_o);

  assert_bad_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid && (!crc_ok || !CMD_MASK[cmd_index])
    |=> $stable(state_o) && $stable(rca_o) && !resp_en_o && !illegal_o);

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!por_n)
    illegal_o |-> !resp_en_o && $stable(state_o));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!por_n)
    !cmd_valid |=> !resp_en_o && !illegal_o);

endmodule

// File: tb/card_ident_fsm_tb.sv
`timescale 1ns/1ps
module card_ident_fsm_tb;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic crc_ok = 1'b1, volt_ok = 1'b1, busy = 1'b0, arb_lost = 1'b0;
  logic [3:0] state_o;
  logic resp_en_o, illegal_o;
  logic [15:0] rca_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  card_ident_fsm u_dut (
    .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .crc_ok(crc_ok), .volt_ok(volt_ok), .busy(busy),
    .arb_lost(arb_lost), .state_o(state_o), .resp_en_o(resp_en_o),
    .illegal_o(illegal_o), .rca_o(rca_o)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [15:0] arg;
    logic        crc, volt, bsy, lost;
    logic [3:0]  st;
    logic        rsp, ill;
    logic [15:0] rca;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{6'd1,  16'h0000, 1'b1,1'b1,1'b1,1'b0, 4'd0,  1'b1,1'b0, 16'h0000}, // R3
    '{6'd2,  16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd0,  1'b0,1'b1, 16'h0000}, // R9
    '{6'd1,  16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd1,  1'b1,1'b0, 16'h0000}, // R2
    '{6'd2,  16'h0000, 1'b1,1'b1,1'b0,1'b1, 4'd1,  1'b0,1'b0, 16'h0000}, // R5
    '{6'd3,  16'h1234, 1'b1,1'b1,1'b0,1'b0, 4'd1,  1'b0,1'b1, 16'h0000}, // R9
    '{6'd2,  16'h0000, 1'b0,1'b1,1'b0,1'b0, 4'd1,  1'b0,1'b0, 16'h0000}, // R8
    '{6'd24, 16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd1,  1'b0,1'b0, 16'h0000}, // R8
    '{6'd2,  16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd2,  1'b1,1'b0, 16'h0000}, // R5
    '{6'd3,  16'h5A5A, 1'b0,1'b1,1'b0,1'b0, 4'd2,  1'b0,1'b0, 16'h0000}, // R8
    '{6'd3,  16'hBEEF, 1'b1,1'b1,1'b0,1'b0, 4'd3,  1'b1,1'b0, 16'hBEEF}, // R6
    '{6'd2,  16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd3,  1'b0,1'b1, 16'hBEEF}, // R9
    '{6'd0,  16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd0,  1'b0,1'b0, 16'h0000}, // R7
    '{6'd1,  16'h0000, 1'b1,1'b0,1'b0,1'b0, 4'd15, 1'b0,1'b0, 16'h0000}, // R4
    '{6'd0,  16'h0000, 1'b1,1'b1,1'b0,1'b0, 4'd15, 1'b0,1'b0, 16'h0000}  // R4
  };
  localparam string VREQ [NV] = '{"R3","R9","R2","R5","R9","R8","R8",
                                  "R5","R8","R6","R9","R7","R4","R4"};

  task automatic check(input string req, input logic [3:0] st, input logic rsp,
                       input logic ill, input logic [15:0] rca);
    total++;
    if (state_o !== st || resp_en_o !== rsp || illegal_o !== ill || rca_o !== rca) begin
      bad++;
      $display("FAIL %s: got st=%0d rsp=%b ill=%b rca=%h exp st=%0d rsp=%b ill=%b rca=%h",
               req, state_o, resp_en_o, illegal_o, rca_o, st, rsp, ill, rca);
    end
  endtask

  task automatic send(input logic [5:0] idx, input logic [15:0] arg, input logic c,
                      input logic v, input logic b, input logic l);
    @(negedge clk);
    cmd_index = idx; cmd_arg = {arg, 16'h0000};
    crc_ok = c; volt_ok = v; busy = b; arb_lost = l; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic power_up();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    power_up();
    check("R1", 4'd0, 1'b0, 1'b0, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].idx, VEC[i].arg, VEC[i].crc, VEC[i].volt, VEC[i].bsy, VEC[i].lost);
      check(VREQ[i], VEC[i].st, VEC[i].rsp, VEC[i].ill, VEC[i].rca);
    end

    send(6'd3, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R4", 4'd15, 1'b0, 1'b0, 16'h0000);

    power_up();
    check("R1", 4'd0, 1'b0, 1'b0, 16'h0000);

    send(6'd1, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(6'd0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", 4'd0, 1'b0, 1'b0, 16'h0000);

    send(6'd1, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(6'd2, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(6'd9, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9", 4'd2, 1'b0, 1'b1, 16'h0000);
    @(negedge clk);
    check("R10", 4'd2, 1'b0, 1'b0, 16'h0000);
    send(6'd0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", 4'd0, 1'b0, 1'b0, 16'h0000);

    send(6'd1, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(6'd2, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(6'd3, 16'h00A7, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R6", 4'd3, 1'b1, 1'b0, 16'h00A7);
    @(negedge clk);
    check("R10", 4'd3, 1'b0, 1'b0, 16'h00A7);
    send(6'd0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", 4'd0, 1'b0, 1'b0, 16'h0000);

    finish_run();
  end
endmodule